// File: doc/BRIEF.md
# Transmit Queue Steering Arbiter

This block keeps the ring pointers of a set of circular transmit queues and decides, every clock cycle, which queue hands its next frame descriptor to the transmit FIFO channels. Each queue is bound to one channel, and several queues may share a channel. The binding is programmable. Each queue also has an active flag and a scheduling-enable flag. A producer moves a queue's write pointer forward as descriptors are posted. The block consumes entries by advancing the read pointer each time it grants that queue.

A queue is eligible when it is active, enabled and not empty. The channel number sets the priority: the command channel 7 beats everything, and among the traffic channels a higher number wins (voice 3, video 2, best effort 1, background 0). Queues that share the winning channel are served round-robin. A grant names the queue, its channel and the ring slot to fetch. The downstream logic takes every grant in the cycle it appears, so one grant is issued per cycle at most.

Top module: `txq_steer`

## Requirements
- R1: After reset, every queue is inactive and disabled, both of its pointers are 0, and `gnt_valid` is low.
- R2: A configuration write (`cfg_we`) sets the channel, active flag and enable flag of queue `cfg_q`. The next clock edge applies them. A grant reports the channel of the granted queue on `gnt_chan`.
- R3: A queue is eligible only when its active flag is 1, its enable flag is 1 and its read pointer differs from its write pointer.
- R4: Among eligible queues, the grant goes to a queue on the highest-numbered channel that has any eligible queue. Channel 7 (commands) wins over all others, and channel 3 wins over 2, 1 and 0.
- R5: Within the winning channel, the search starts at the queue index after the last queue granted on that channel and wraps modulo 16. After reset the search in each channel starts at queue 0.
- R6: `gnt_idx` is the granted queue's read pointer. The grant moves that pointer forward by one, modulo 256, so slot 255 is followed by slot 0.
- R7: A write-pointer write (`wp_we`) sets the write pointer of queue `wp_q` to `wp_val`. It leaves the other queues unchanged.
- R8: When no queue is eligible, `gnt_valid` is low and `gnt_q`, `gnt_chan` and `gnt_idx` are 0.
- R9: Clearing a queue's active or enable flag stops its grants and keeps its read pointer. Setting the flag again resumes the queue at the slot where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Queue configuration write strobe |
| cfg_q | input | 4 | Queue being configured |
| cfg_chan | input | 3 | Channel bound to the queue |
| cfg_active | input | 1 | Queue active flag |
| cfg_sched_en | input | 1 | Queue scheduling enable |
| wp_we | input | 1 | Write-pointer update strobe |
| wp_q | input | 4 | Queue whose write pointer is set |
| wp_val | input | 8 | New write pointer value |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_q | output | 4 | Granted queue |
| gnt_chan | output | 3 | Channel of the granted queue |
| gnt_idx | output | 8 | Ring slot of the granted descriptor |

## Verification
The stimulus puts queues on the command channel and on two traffic channels at once. This shows whether a grant follows channel priority rather than queue index. Two queues share background channel 0 and are kept full enough to alternate, which exposes a round-robin pointer that fails to move or moves in the wrong channel. One queue is active but not enabled, and another is taken out of service in the middle of a burst and then brought back. These cases separate the three eligibility terms and show that the read pointer survives a pause. A long drain of one queue past slot 255 checks the ring wrap.

// File: rtl/txq_steer.sv
module txq_steer #(
  parameter int NQ  = 16,
  parameter int NCH = 8,
  parameter int PW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NQ)-1:0]  cfg_q,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic                   cfg_active,
  input  logic                   cfg_sched_en,
  input  logic                   wp_we,
  input  logic [$clog2(NQ)-1:0]  wp_q,
  input  logic [PW-1:0]          wp_val,
  output logic                   gnt_valid,
  output logic [$clog2(NQ)-1:0]  gnt_q,
  output logic [$clog2(NCH)-1:0] gnt_chan,
  output logic [PW-1:0]          gnt_idx
);
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCH);

  logic [CW-1:0]  q_ch [NQ];
  logic [NQ-1:0]  q_act, q_en;
  logic [PW-1:0]  rp [NQ];
  logic [PW-1:0]  wp [NQ];
  logic [QW-1:0]  last [NCH];

  logic [NQ-1:0]  elig;
  logic [NCH-1:0] ch_busy;
  logic [CW-1:0]  sel_ch;
  logic [QW-1:0]  pick;

  for (genvar q = 0; q < NQ; q++) begin : g_elig
    assign elig[q] = q_act[q] & q_en[q] & (rp[q] != wp[q]);
  end

  always_comb begin
    ch_busy = '0;
    for (int q = 0; q < NQ; q++)
      if (elig[q]) ch_busy[q_ch[q]] = 1'b1;
  end

  always_comb begin
    sel_ch = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_busy[c]) sel_ch = CW'(c);
  end

  always_comb begin
    int k;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int i = 1; i <= NQ; i++) begin
      k = (int'(last[sel_ch]) + i) % NQ;
      if (!found && elig[k] && q_ch[k] == sel_ch) begin
        pick  = QW'(k);
        found = 1'b1;
      end
    end
  end

  assign gnt_valid = |elig;
  assign gnt_q     = gnt_valid ? pick : '0;
  assign gnt_chan  = gnt_valid ? sel_ch : '0;
  assign gnt_idx   = gnt_valid ? rp[pick] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_act <= '0;
      q_en  <= '0;
      for (int q = 0; q < NQ; q++) begin
        q_ch[q] <= '0;
        rp[q]   <= '0;
        wp[q]   <= '0;
      end
      for (int c = 0; c < NCH; c++) last[c] <= QW'(NQ - 1);
    end else begin
      if (cfg_we) begin
        q_ch[cfg_q]  <= cfg_chan;
        q_act[cfg_q] <= cfg_active;
        q_en[cfg_q]  <= cfg_sched_en;
      end
      if (wp_we) wp[wp_q] <= wp_val;
      if (gnt_valid) begin
        rp[pick]     <= rp[pick] + 1'b1;
        last[sel_ch] <= pick;
      end
    end
  end

  // R3
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (q_act[gnt_q] && q_en[gnt_q] && rp[gnt_q] != wp[gnt_q]));

  // R2
  grant_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_chan == q_ch[gnt_q]);

  // R4
  grant_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (ch_busy >> gnt_chan) == NCH'(1));

  // R6
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> rp[$past(gnt_q)] == PW'($past(gnt_idx) + 1'b1));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> (!gnt_valid && gnt_q == '0 && gnt_idx == '0));
endmodule

// File: tb/tb_txq_steer.sv
`timescale 1ns/1ps
module tb_txq_steer;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_active = 0, cfg_sched_en = 0, wp_we = 0;
  logic [3:0] cfg_q = 0, wp_q = 0;
  logic [2:0] cfg_chan = 0;
  logic [7:0] wp_val = 0;
  logic gnt_valid;
  logic [3:0] gnt_q;
  logic [2:0] gnt_chan;
  logic [7:0] gnt_idx;

  always #5 clk = ~clk;

  txq_steer dut (.*);

  int total = 0, bad = 0;
  int m_ch[16], m_act[16], m_en[16], m_rp[16], m_wp[16], m_last[8];
  bit saw_wrap = 0;
  int prev_idx5 = -1;

  // op: 0 idle (a = cycles), 1 cfg (q, a = chan, b bit0 act bit1 en), 2 write pointer (q, a = value)
  localparam int NV = 26;
  localparam int VEC [NV][4] = '{
    '{2, 0, 3, 0}, '{2, 1, 2, 0}, '{2, 4, 2, 0}, '{2, 9, 2, 0}, '{2, 12, 3, 0},
    '{1, 0, 0, 3}, '{1, 1, 0, 3}, '{1, 4, 2, 3}, '{1, 9, 7, 3}, '{1, 12, 2, 1},
    '{0, 0, 10, 0},
    '{1, 12, 2, 3}, '{0, 0, 5, 0},
    '{2, 1, 40, 0}, '{2, 0, 40, 0}, '{0, 0, 6, 0},
    '{1, 1, 0, 2}, '{0, 0, 8, 0}, '{1, 0, 0, 1}, '{0, 0, 4, 0},
    '{1, 1, 0, 3}, '{1, 0, 0, 3}, '{2, 9, 6, 0}, '{1, 2, 3, 3}, '{2, 2, 4, 0},
    '{0, 0, 90, 0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < 16; q++) begin
      m_ch[q] = 0; m_act[q] = 0; m_en[q] = 0; m_rp[q] = 0; m_wp[q] = 0;
    end
    for (int c = 0; c < 8; c++) m_last[c] = 15;
  endtask

  task automatic check_and_advance();
    int ev, eq, ec, k;
    ev = 0; eq = 0; ec = -1;
    for (int q = 0; q < 16; q++)
      if (m_act[q] != 0 && m_en[q] != 0 && m_rp[q] != m_wp[q] && m_ch[q] > ec) ec = m_ch[q];
    if (ec >= 0) begin
      for (int i = 1; i <= 16 && ev == 0; i++) begin
        k = (m_last[ec] + i) % 16;
        if (m_act[k] != 0 && m_en[k] != 0 && m_rp[k] != m_wp[k] && m_ch[k] == ec) begin
          ev = 1; eq = k;
        end
      end
    end
    chk(gnt_valid == ev[0], "R3 R7 R9 grant valid", gnt_valid, ev);
    if (ev != 0) begin
      chk(gnt_q == eq[3:0], "R4 R5 granted queue", gnt_q, eq);
      chk(gnt_chan == ec[2:0], "R2 R4 granted channel", gnt_chan, ec);
      chk(gnt_idx == m_rp[eq][7:0], "R6 descriptor index", gnt_idx, m_rp[eq]);
      if (eq == 5) begin
        if (prev_idx5 == 255 && gnt_idx == 0) saw_wrap = 1;
        prev_idx5 = gnt_idx;
      end
      m_rp[eq] = (m_rp[eq] + 1) % 256;
      m_last[ec] = eq;
    end else begin
      chk(gnt_q == 0 && gnt_chan == 0 && gnt_idx == 0, "R8 idle outputs zero",
          {gnt_q, gnt_chan, gnt_idx}, 0);
    end
  endtask

  task automatic cyc(input int op, input int q, input int a, input int b);
    @(negedge clk);
    check_and_advance();
    cfg_we = 0; wp_we = 0;
    if (op == 1) begin
      cfg_we = 1; cfg_q = q[3:0]; cfg_chan = a[2:0]; cfg_active = b[0]; cfg_sched_en = b[1];
      m_ch[q] = a; m_act[q] = b & 1; m_en[q] = (b >> 1) & 1;
    end else if (op == 2) begin
      wp_we = 1; wp_q = q[3:0]; wp_val = a[7:0];
      m_wp[q] = a;
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(gnt_valid == 0, "R1 no grant in reset", gnt_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(gnt_valid == 0, "R1 no grant after reset", gnt_valid, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][0] == 0) begin
        for (int n = 0; n < VEC[v][2]; n++) cyc(0, 0, 0, 0);
      end else begin
        cyc(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      end
    end

    // R6: drain queue 5 across the 255 -> 0 ring boundary
    cyc(2, 5, 200, 0);
    cyc(1, 5, 3, 3);
    for (int n = 0; n < 205; n++) cyc(0, 0, 0, 0);
    cyc(2, 5, 10, 0);
    for (int n = 0; n < 75; n++) cyc(0, 0, 0, 0);
    chk(saw_wrap, "R6 ring wrap from 255 to 0", saw_wrap, 1);

    // R1: reset in mid-run clears queues
    cyc(2, 7, 9, 0);
    cyc(1, 7, 1, 3);
    cyc(0, 0, 0, 0);
    @(negedge clk);
    rst_n = 0;
    cfg_we = 0; wp_we = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk(gnt_valid == 0, "R1 queues inactive after reset", gnt_valid, 0);
    for (int n = 0; n < 3; n++) cyc(0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule